// File: doc/BRIEF.md
# Split-Line Memory Permission Checker

This block decides, for every request on an instruction-side SRAM bus and a data-side SRAM bus, whether the access is allowed. Programmable split addresses divide the address space seen by each bus into four areas. Each instruction area has its own read, write and execute grants. Each data area has its own read and write grants. The decision is combinational, so the allow bit is valid in the same cycle as the request.

A single write port loads the five split lines, the two permission sets and three sticky lock bits. Split lines must be 512-byte aligned. A lock bit can only be cleared by reset. While the split lock is set, all split lines are frozen. Each bus's permission set has its own lock.

The data side uses its own two lines. Its upper area boundary is the shared main instruction/data split, taken in the same address view. Address translation between the two bus views is outside this block.

Top module: `mpc_split_guard`

## Requirements
- R1: After reset all split lines are zero, every permission bit is granted and every lock is clear, so every valid request on either bus is allowed.
- R2: An instruction address selects its area from the first matching rule, checked in this order, with unsigned compares:
  - area 0 if it is below instruction line 0;
  - area 1 if it is below instruction line 1;
  - area 2 if it is below the main split;
  - area 3 otherwise.
- R3: A data address selects its area the same way, using data line 0, data line 1 and the main split, in that order.
- R4: The instruction access kind selects one grant bit:
  - kind 0 is a load and needs read;
  - kind 1 is a store and needs write;
  - kind 2 is a fetch and needs execute;
  - kind 3 is reserved and is always denied.
- R5: A data access needs the read grant when the direction bit is 0 and the write grant when it is 1.
- R6: An allow output is 0 whenever its valid input is 0. With valid high, the allow output follows the request in the same cycle with no register on the path.
- R7: Config select codes are:
  - 0 for instruction line 0, 1 for instruction line 1, 2 for the main split;
  - 3 for data line 0, 4 for data line 1;
  - 5 for instruction permissions, 6 for data permissions, 7 for locks.
  A write to codes 0 to 4 whose low 9 data bits are not all zero is ignored.
- R8: A write to code 7 sets lock bits and never clears them. Bit 0 locks the split lines, bit 1 locks instruction permissions and bit 2 locks data permissions. Writing 0 has no effect, and only reset clears a lock.
- R9: While the split lock is set, writes to codes 0 to 4 are ignored.
- R10: Instruction permissions use data bits [11:0]. Area a takes bits [3a+2:3a], ordered execute, write, read from high to low. While the instruction lock is set, writes to code 5 are ignored and data permissions remain writable.
- R11: Data permissions use data bits [7:0]. Area a takes bits [2a+1:2a], ordered write, read from high to low. While the data lock is set, writes to code 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 3 | Config register select |
| cfg_wdata_i | input | ADDR_W | Config write data |
| ibus_valid_i | input | 1 | Instruction-bus request valid |
| ibus_addr_i | input | ADDR_W | Instruction-bus address |
| ibus_kind_i | input | 2 | Instruction-bus access kind |
| ibus_allow_o | output | 1 | Instruction-bus access allowed |
| dbus_valid_i | input | 1 | Data-bus request valid |
| dbus_addr_i | input | ADDR_W | Data-bus address |
| dbus_write_i | input | 1 | Data-bus direction, 1 is write |
| dbus_allow_o | output | 1 | Data-bus access allowed |

## Verification
Directed probes at one byte below and exactly at each split line show whether a boundary is exclusive or inclusive. Probes with out-of-order lines show whether the rules are applied in priority order.

A typical configuration, with execute-only and read-only areas, separates the three instruction kinds and the two data directions. It shows a wrong grant-bit mapping, or a wrong choice of neighbouring area. Misaligned writes and locked writes are each followed by probes whose result would differ had the write landed.

Random configurations and addresses clustered around the programmed lines then compare every decision with a bench model of the rules.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int N_ILINES    = 3;
  localparam int N_DLINES    = 2;
  localparam int N_LINES     = N_ILINES + N_DLINES;
  localparam int N_AREAS     = 4;
  localparam int AREA_W      = $clog2(N_AREAS);
  localparam int I_PERM_W    = 3;
  localparam int D_PERM_W    = 2;
  localparam int I_PERM_BITS = N_AREAS * I_PERM_W;
  localparam int D_PERM_BITS = N_AREAS * D_PERM_W;
  localparam int N_LOCKS     = 3;
  localparam int SEL_W       = 3;
  localparam int KIND_W      = 2;

  // select code k for k < N_LINES addresses split line k
  typedef enum logic [SEL_W-1:0] {
    SEL_I_LINE0 = 3'd0,
    SEL_I_LINE1 = 3'd1,
    SEL_I_MAIN  = 3'd2,
    SEL_D_LINE0 = 3'd3,
    SEL_D_LINE1 = 3'd4,
    SEL_I_PERM  = 3'd5,
    SEL_D_PERM  = 3'd6,
    SEL_LOCK    = 3'd7
  } cfg_sel_e;

  typedef enum logic [KIND_W-1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } ikind_e;

  localparam int LK_SPLIT = 0;
  localparam int LK_IPERM = 1;
  localparam int LK_DPERM = 2;
endpackage

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
  import mpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [ADDR_W-1:0]               wdata_i,
  output logic [N_LINES-1:0][ADDR_W-1:0]  lines_o,
  output logic [I_PERM_BITS-1:0]          i_perm_o,
  output logic [D_PERM_BITS-1:0]          d_perm_o,
  output logic [N_LOCKS-1:0]              lock_o
);
  logic                   aligned;
  logic [N_LOCKS-1:0]     lock_q;
  logic [I_PERM_BITS-1:0] i_perm_q;
  logic [D_PERM_BITS-1:0] d_perm_q;
  logic [ADDR_W-1:0]      lines_q [N_LINES];

  assign aligned = (wdata_i[ALIGN_BITS-1:0] == '0);

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        lines_q[k] <= '0;
      else if (we_i && sel_i == SEL_W'(k) && !lock_q[LK_SPLIT] && aligned)
        lines_q[k] <= wdata_i;
    end
    assign lines_o[k] = lines_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_perm_q <= '1;
      d_perm_q <= '1;
      lock_q   <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_I_PERM && !lock_q[LK_IPERM])
        i_perm_q <= wdata_i[I_PERM_BITS-1:0];
      if (sel_i == SEL_D_PERM && !lock_q[LK_DPERM])
        d_perm_q <= wdata_i[D_PERM_BITS-1:0];
      if (sel_i == SEL_LOCK)
        lock_q <= lock_q | wdata_i[N_LOCKS-1:0];
    end
  end

  assign i_perm_o = i_perm_q;
  assign d_perm_o = d_perm_q;
  assign lock_o   = lock_q;
endmodule

// File: rtl/mpc_area_sel.sv
module mpc_area_sel #(
  parameter int ADDR_W  = 32,
  parameter int N_LINES = 3,
  localparam int SEL_AW = $clog2(N_LINES + 1)
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [N_LINES-1:0][ADDR_W-1:0] lines_i,
  output logic [SEL_AW-1:0]              area_o
);
  // lowest-index line above the address wins
  always_comb begin
    area_o = SEL_AW'(N_LINES);
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (addr_i < lines_i[i]) area_o = SEL_AW'(i);
    end
  end
endmodule

// File: rtl/mpc_perm_check.sv
module mpc_perm_check #(
  parameter int PERM_W  = 3,
  parameter int N_AREAS = 4,
  parameter int REQ_W   = 2,
  localparam int AW     = $clog2(N_AREAS),
  localparam int IW     = (PERM_W > 1) ? $clog2(PERM_W) : 1
) (
  input  logic                        valid_i,
  input  logic [AW-1:0]               area_i,
  input  logic [REQ_W-1:0]            req_i,
  input  logic [N_AREAS*PERM_W-1:0]   perms_i,
  output logic                        allow_o
);
  logic [PERM_W-1:0] grant;
  logic              req_ok;

  assign grant  = perms_i[area_i*PERM_W +: PERM_W];
  assign req_ok = (int'(req_i) < PERM_W);

  always_comb begin
    allow_o = 1'b0;
    if (valid_i && req_ok) allow_o = grant[req_i[IW-1:0]];
  end
endmodule

// File: rtl/mpc_split_guard.sv
module mpc_split_guard
  import mpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              ibus_valid_i,
  input  logic [ADDR_W-1:0] ibus_addr_i,
  input  logic [1:0]        ibus_kind_i,
  output logic              ibus_allow_o,
  input  logic              dbus_valid_i,
  input  logic [ADDR_W-1:0] dbus_addr_i,
  input  logic              dbus_write_i,
  output logic              dbus_allow_o
);
  logic [N_LINES-1:0][ADDR_W-1:0]  cfg_lines;
  logic [I_PERM_BITS-1:0]          i_perm;
  logic [D_PERM_BITS-1:0]          d_perm;
  logic [N_LOCKS-1:0]              lock;
  logic [2:0][ADDR_W-1:0]          i_bounds;
  logic [2:0][ADDR_W-1:0]          d_bounds;
  logic [AREA_W-1:0]               i_area;
  logic [AREA_W-1:0]               d_area;

  mpc_cfg_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .lines_o  (cfg_lines),
    .i_perm_o (i_perm),
    .d_perm_o (d_perm),
    .lock_o   (lock)
  );

  assign i_bounds[0] = cfg_lines[SEL_I_LINE0];
  assign i_bounds[1] = cfg_lines[SEL_I_LINE1];
  assign i_bounds[2] = cfg_lines[SEL_I_MAIN];
  // data side tops out at the shared main split
  assign d_bounds[0] = cfg_lines[SEL_D_LINE0];
  assign d_bounds[1] = cfg_lines[SEL_D_LINE1];
  assign d_bounds[2] = cfg_lines[SEL_I_MAIN];

  mpc_area_sel #(.ADDR_W(ADDR_W), .N_LINES(3)) u_isel (
    .addr_i  (ibus_addr_i),
    .lines_i (i_bounds),
    .area_o  (i_area)
  );

  mpc_area_sel #(.ADDR_W(ADDR_W), .N_LINES(3)) u_dsel (
    .addr_i  (dbus_addr_i),
    .lines_i (d_bounds),
    .area_o  (d_area)
  );

  mpc_perm_check #(.PERM_W(I_PERM_W), .N_AREAS(N_AREAS), .REQ_W(KIND_W)) u_ichk (
    .valid_i (ibus_valid_i),
    .area_i  (i_area),
    .req_i   (ibus_kind_i),
    .perms_i (i_perm),
    .allow_o (ibus_allow_o)
  );

  mpc_perm_check #(.PERM_W(D_PERM_W), .N_AREAS(N_AREAS), .REQ_W(KIND_W)) u_dchk (
    .valid_i (dbus_valid_i),
    .area_i  (d_area),
    .req_i   ({1'b0, dbus_write_i}),
    .perms_i (d_perm),
    .allow_o (dbus_allow_o)
  );
endmodule

// File: rtl/mpc_split_guard_chk.sv
module mpc_split_guard_chk
  import mpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 9
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           cfg_we_i,
  input logic [2:0]                     cfg_sel_i,
  input logic [ADDR_W-1:0]              cfg_wdata_i,
  input logic                           ibus_valid_i,
  input logic [1:0]                     ibus_kind_i,
  input logic                           ibus_allow_o,
  input logic                           dbus_valid_i,
  input logic                           dbus_allow_o,
  input logic [N_LINES-1:0][ADDR_W-1:0] lines,
  input logic [I_PERM_BITS-1:0]         i_perm,
  input logic [D_PERM_BITS-1:0]         d_perm,
  input logic [N_LOCKS-1:0]             lock
);
  a_r6_ibus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ibus_valid_i |-> !ibus_allow_o);

  a_r6_dbus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbus_valid_i |-> !dbus_allow_o);

  a_r4_rsvd_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ibus_valid_i && ibus_kind_i == KIND_RSVD) |-> !ibus_allow_o);

  a_r7_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && int'(cfg_sel_i) < N_LINES && cfg_wdata_i[ALIGN_BITS-1:0] != '0)
      |=> $stable(lines));

  a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock & $past(lock)) == $past(lock)));

  a_r9_split_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock[LK_SPLIT] |=> $stable(lines));

  a_r10_iperm_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock[LK_IPERM] |=> $stable(i_perm));

  a_r11_dperm_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock[LK_DPERM] |=> $stable(d_perm));
endmodule

bind mpc_split_guard mpc_split_guard_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_sel_i    (cfg_sel_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .ibus_valid_i (ibus_valid_i),
  .ibus_kind_i  (ibus_kind_i),
  .ibus_allow_o (ibus_allow_o),
  .dbus_valid_i (dbus_valid_i),
  .dbus_allow_o (dbus_allow_o),
  .lines        (cfg_lines),
  .i_perm       (i_perm),
  .d_perm       (d_perm),
  .lock         (lock)
);

// File: tb/sim_mpc_split_guard.sv
`timescale 1ns/1ps
module sim_mpc_split_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ivalid = 1'b0;
  logic [31:0] iaddr = '0;
  logic [1:0]  ikind = '0;
  logic        iallow;
  logic        dvalid = 1'b0;
  logic [31:0] daddr = '0;
  logic        dwrite = 1'b0;
  logic        dallow;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_line [5];
  logic [11:0] m_iperm;
  logic [7:0]  m_dperm;
  logic [2:0]  m_lock;

  always #2.5 clk = ~clk;

  mpc_split_guard u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .ibus_valid_i(ivalid), .ibus_addr_i(iaddr), .ibus_kind_i(ikind), .ibus_allow_o(iallow),
    .dbus_valid_i(dvalid), .dbus_addr_i(daddr), .dbus_write_i(dwrite), .dbus_allow_o(dallow)
  );

  function automatic int area_of(logic [31:0] a, logic [31:0] b0, logic [31:0] b1, logic [31:0] b2);
    if (a < b0) return 0;
    if (a < b1) return 1;
    if (a < b2) return 2;
    return 3;
  endfunction

  function automatic logic exp_i(logic [31:0] a, logic [1:0] k);
    int ar = area_of(a, m_line[0], m_line[1], m_line[2]);
    if (k == 2'd3) return 1'b0;
    return m_iperm[ar*3 + int'(k)];
  endfunction

  function automatic logic exp_d(logic [31:0] a, logic w);
    int ar = area_of(a, m_line[3], m_line[4], m_line[2]);
    return m_dperm[ar*2 + int'(w)];
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    // model of the write rules
    if (sel < 3'd5) begin
      if (!m_lock[0] && data[8:0] == 9'd0) m_line[sel] = data;
    end else if (sel == 3'd5) begin
      if (!m_lock[1]) m_iperm = data[11:0];
    end else if (sel == 3'd6) begin
      if (!m_lock[2]) m_dperm = data[7:0];
    end else begin
      m_lock = m_lock | data[2:0];
    end
  endtask

  task automatic probe(input logic [31:0] ia, input logic [1:0] ik,
                       input logic [31:0] da, input logic dw, input string tag);
    @(negedge clk);
    ivalid = 1'b1; iaddr = ia; ikind = ik;
    dvalid = 1'b1; daddr = da; dwrite = dw;
    #1;
    check(iallow, exp_i(ia, ik), {tag, " ibus"});
    check(dallow, exp_d(da, dw), {tag, " dbus"});
    ivalid = 1'b0; dvalid = 1'b0;
    #1;
    check(iallow, 1'b0, "R6 ibus idle");
    check(dallow, 1'b0, "R6 dbus idle");
  endtask

  function automatic logic [31:0] pick_addr();
    if ($urandom_range(0, 3) == 0) return $urandom & 32'h0001_FFFF;
    return m_line[$urandom_range(0, 4)] + 32'($urandom_range(0, 2)) - 32'd1;
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) m_line[i] = '0;
    m_iperm = '1; m_dperm = '1; m_lock = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: all granted everywhere
    probe(32'h0, 2'd0, 32'h0, 1'b0, "R1 reset");
    probe(32'hFFFF_FFFF, 2'd1, 32'hFFFF_FFFF, 1'b1, "R1 reset");
    probe(32'h0000_4000, 2'd2, 32'h0000_4000, 1'b1, "R1 reset");

    // typical layout
    cfg_write(3'd0, 32'h1000);
    cfg_write(3'd1, 32'h2000);
    cfg_write(3'd2, 32'h3000);
    cfg_write(3'd3, 32'h1400);
    cfg_write(3'd4, 32'h2400);
    cfg_write(3'd5, 32'h76D);   // areas 0-2 x+r, area 3 w+r (R10 layout)
    cfg_write(3'd6, 32'hFD);    // area 0 r only, others w+r (R11 layout)

    for (int k = 0; k < 4; k++) begin
      probe(32'h0FFF, 2'(k), 32'h13FF, k[0], "R2 R3 R4 R5 below line0");
      probe(32'h1000, 2'(k), 32'h1400, k[0], "R2 R3 R4 R5 at line0");
      probe(32'h1FFF, 2'(k), 32'h23FF, k[0], "R2 R3 at line1-1");
      probe(32'h2000, 2'(k), 32'h2400, k[0], "R2 R3 at line1");
      probe(32'h2FFF, 2'(k), 32'h2FFF, k[0], "R2 R3 below main");
      probe(32'h3000, 2'(k), 32'h3000, k[0], "R2 R3 at main");
    end

    // make area 0 differ from area 1 on loads, then misaligned line move
    cfg_write(3'd5, 32'h76C);
    cfg_write(3'd0, 32'h1100);
    probe(32'h1080, 2'd0, 32'h1080, 1'b1, "R7 misaligned ignored");
    cfg_write(3'd3, 32'h1001);
    probe(32'h1080, 2'd0, 32'h1200, 1'b1, "R7 misaligned ignored");
    cfg_write(3'd0, 32'h1200);
    probe(32'h1080, 2'd0, 32'h1080, 1'b0, "R7 aligned accepted");

    // out-of-order lines: priority order
    cfg_write(3'd1, 32'h0800);
    probe(32'h0900, 2'd0, 32'h0900, 1'b0, "R2 priority");
    probe(32'h0700, 2'd2, 32'h0700, 1'b1, "R2 priority");

    // random phase, no locks
    for (int it = 0; it < 400; it++) begin
      logic [2:0]  s;
      logic [31:0] d;
      s = 3'($urandom_range(0, 6));
      if (s < 3'd5) begin
        d = $urandom & 32'h0001_FE00;
        if ($urandom_range(0, 3) == 0) d = d | 32'($urandom_range(1, 511));
      end else begin
        d = $urandom;
      end
      cfg_write(s, d);
      for (int p = 0; p < 3; p++)
        probe(pick_addr(), 2'($urandom_range(0, 3)), pick_addr(), 1'($urandom_range(0, 1)),
              "R2 R3 R4 R5 R7 random");
    end

    // split lock
    cfg_write(3'd0, 32'h1000);
    cfg_write(3'd1, 32'h2000);
    cfg_write(3'd2, 32'h3000);
    cfg_write(3'd3, 32'h1000);
    cfg_write(3'd4, 32'h2000);
    cfg_write(3'd5, 32'h0C7);   // area0 rwx, area1 none, area2 w+r, area3 none
    cfg_write(3'd6, 32'h03);    // area0 rw, rest none
    cfg_write(3'd7, 32'h1);
    cfg_write(3'd0, 32'h1800);
    probe(32'h1400, 2'd0, 32'h1400, 1'b0, "R9 split write ignored");
    cfg_write(3'd3, 32'h1800);
    probe(32'h0FFF, 2'd2, 32'h1400, 1'b1, "R9 split write ignored");
    cfg_write(3'd7, 32'h0);
    cfg_write(3'd2, 32'h2000);
    probe(32'h2800, 2'd1, 32'h0800, 1'b1, "R8 zero write keeps lock");
    cfg_write(3'd5, 32'hFFF);
    probe(32'h1400, 2'd2, 32'h0800, 1'b0, "R10 iperm still writable");

    // instruction permission lock
    cfg_write(3'd7, 32'h2);
    cfg_write(3'd5, 32'h000);
    probe(32'h1400, 2'd0, 32'h0800, 1'b0, "R10 iperm write ignored");
    cfg_write(3'd6, 32'hFF);
    probe(32'h1400, 2'd1, 32'h2800, 1'b1, "R10 dperm still writable");

    // data permission lock
    cfg_write(3'd7, 32'h4);
    cfg_write(3'd6, 32'h00);
    probe(32'h3400, 2'd2, 32'h2800, 1'b1, "R11 dperm write ignored");
    probe(32'h0400, 2'd1, 32'h0400, 1'b0, "R11 dperm write ignored");

    // random writes against a fully locked block
    for (int it = 0; it < 60; it++) begin
      cfg_write(3'($urandom_range(0, 7)), $urandom & 32'h0001_FE00);
      probe(pick_addr(), 2'($urandom_range(0, 3)), pick_addr(), 1'($urandom_range(0, 1)),
            "R8 R9 R10 R11 locked random");
    end

    summary();
    $finish;
  end
endmodule